// File: doc/BRIEF.md
# Tile Dirty Tracking Unit

This block sits beside a 16 KB byte-wide video memory. It watches every byte write and records which 32-byte tile patterns have changed, so that a later redraw stage only has to rebuild those tiles. For each tile it keeps an 8-bit change mask. Each bit of the mask stands for one 4-byte row group inside the tile.

A write counts only if the new byte differs from the byte already stored at that address. The writer supplies both bytes in the same cycle. Alongside the masks, the block builds a list of dirty tile indices. The list holds each tile once, in the order in which the tiles first became dirty. A consumer reads the list through an entry-indexed port and reads the masks through a tile-indexed port. When it has finished its redraw pass, it pulses the clear input.

Top module: `tdt_tracker`

## Requirements
- R1: After reset the list count is 0, every mask reads 0 and every list entry reads 0.
- R2: The tile index of a write is wr_addr[13:5]. The mask bit set is the one whose position equals wr_addr[4:2], so position 7 means the group at byte offsets 28..31 of the tile.
- R3: A write whose wr_data equals wr_old changes neither any mask nor the list or its count.
- R4: The mask bits of a tile accumulate by OR over the changing writes to that tile.
- R5: A changing write to a tile whose mask is zero appends that tile's index to the list, at entry number equal to the old count, and the count rises by one.
- R6: A changing write to a tile whose mask is already non-zero does not append it again.
- R7: List entries keep the order in which their tiles first became dirty.
- R8: A clear pulse zeroes all masks and the count in one cycle. It takes priority over a write in the same cycle, and that write is dropped.
- R9: Both read ports are registered, with one cycle of latency. A list entry at an index equal to or above the count reads 0.
- R10: After a clear, a tile that is dirtied again shows only the newly set bits, and list filling restarts at entry 0.
- R11: All 512 tiles can be listed; the count then reads 512.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Byte write strobe into video memory |
| wr_addr | input | 14 | Byte address of the write |
| wr_data | input | 8 | Byte being written |
| wr_old | input | 8 | Byte currently stored at wr_addr |
| clr | input | 1 | Clear all masks and empty the list |
| list_idx | input | 9 | List entry number to read |
| list_tile | output | 9 | Tile index at list_idx, one cycle later |
| list_count | output | 10 | Number of valid list entries |
| mask_tile | input | 9 | Tile whose mask is read |
| mask_bits | output | 8 | Mask of mask_tile, one cycle later |

## Verification
The bench writes to the top tile at the highest row group, so that a wrong address slice shows up as a wrong tile or bit. It also repeats writes to one tile: a design that tests the old mask wrongly would list that tile twice and overcount. One write carries identical new and old bytes, which catches a design that marks tiles on every strobe. Other cases fire a clear together with a write to a fresh tile, and redirty a tile after a clear. These expose a design that lets the write win, or one that keeps stale mask bits because its clear only reset a valid flag. The bench fills all 512 tiles in reverse order to check capacity and ordering at the point where the count needs its extra bit.

// File: rtl/tdt_pkg.sv
package tdt_pkg;
  // Default geometry of the tracked memory.
  localparam int DEF_ADDR_W     = 14;  // byte address width
  localparam int DEF_TILE_LOG2  = 5;   // bytes per tile = 2**5
  localparam int DEF_GROUP_LOG2 = 2;   // bytes per row group = 2**2
  localparam int DEF_DATA_W     = 8;

  // Turn a row-group select into a one-hot mask bit.
  function automatic logic [31:0] group_bit(input logic [4:0] sel);
    return 32'd1 << sel;
  endfunction
endpackage

// File: rtl/tdt_mask_store.sv
module tdt_mask_store #(
  parameter int TILE_W = 9,
  parameter int SEL_W  = 3,
  localparam int NUM_TILES = 1 << TILE_W,
  localparam int MASK_W    = 1 << SEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              upd_en,
  input  logic [TILE_W-1:0] upd_tile,
  input  logic [SEL_W-1:0]  upd_sel,
  output logic              first_touch,
  input  logic [TILE_W-1:0] rd_tile,
  output logic [MASK_W-1:0] rd_mask
);
  import tdt_pkg::*;

  // Per-tile "mask is non-zero" flags; the mask array itself holds no reset.
  logic [NUM_TILES-1:0] valid_q, valid_d;
  logic [MASK_W-1:0]    mask_mem [NUM_TILES];
  logic [MASK_W-1:0]    old_mask, new_mask, sel_bit;
  logic [MASK_W-1:0]    rd_mask_q, rd_mask_d;
  logic                 mem_we;

  always_comb begin
    sel_bit     = MASK_W'(group_bit(5'(upd_sel)));
    first_touch = !valid_q[upd_tile];
    old_mask    = valid_q[upd_tile] ? mask_mem[upd_tile] : '0;
    new_mask    = old_mask | sel_bit;
    mem_we      = upd_en && !clr;
  end

  always_comb begin
    valid_d = valid_q;
    if (clr)
      valid_d = '0;
    else if (upd_en)
      valid_d[upd_tile] = 1'b1;
  end

  always_comb begin
    rd_mask_d = valid_q[rd_tile] ? mask_mem[rd_tile] : '0;
  end

  always_ff @(posedge clk) begin
    if (mem_we)
      mask_mem[upd_tile] <= new_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q   <= '0;
      rd_mask_q <= '0;
    end else begin
      valid_q   <= valid_d;
      rd_mask_q <= rd_mask_d;
    end
  end

  assign rd_mask = rd_mask_q;

  // R3
  same_byte_no_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_en && !clr) |=> $stable(valid_q));

  // R8
  clear_empties_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (valid_q == '0));
endmodule

// File: rtl/tdt_tile_list.sv
module tdt_tile_list #(
  parameter int TILE_W = 9,
  localparam int DEPTH = 1 << TILE_W,
  localparam int CNT_W = TILE_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              push,
  input  logic [TILE_W-1:0] push_tile,
  input  logic [TILE_W-1:0] rd_idx,
  output logic [TILE_W-1:0] rd_tile,
  output logic [CNT_W-1:0]  count
);
  logic [TILE_W-1:0] list_mem [DEPTH];
  logic [CNT_W-1:0]  count_q, count_d;
  logic [TILE_W-1:0] rd_q, rd_d;
  logic              mem_we;

  always_comb begin
    mem_we  = push && !clr;
    count_d = count_q;
    if (clr)
      count_d = '0;
    else if (push)
      count_d = count_q + CNT_W'(1);
  end

  always_comb begin
    rd_d = (CNT_W'(rd_idx) < count_q) ? list_mem[rd_idx] : '0;
  end

  always_ff @(posedge clk) begin
    if (mem_we)
      list_mem[count_q[TILE_W-1:0]] <= push_tile;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      rd_q    <= '0;
    end else begin
      count_q <= count_d;
      rd_q    <= rd_d;
    end
  end

  assign count   = count_q;
  assign rd_tile = rd_q;

  // R11
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CNT_W'(DEPTH));

  // R8
  clear_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count_q == '0));

  // R5
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q != $past(count_q)) |-> (count_q == '0 || count_q == $past(count_q) + CNT_W'(1)));
endmodule

// File: rtl/tdt_tracker.sv
module tdt_tracker #(
  parameter int ADDR_W     = tdt_pkg::DEF_ADDR_W,
  parameter int TILE_LOG2  = tdt_pkg::DEF_TILE_LOG2,
  parameter int GROUP_LOG2 = tdt_pkg::DEF_GROUP_LOG2,
  parameter int DATA_W     = tdt_pkg::DEF_DATA_W,
  localparam int TILE_W = ADDR_W - TILE_LOG2,
  localparam int SEL_W  = TILE_LOG2 - GROUP_LOG2,
  localparam int MASK_W = 1 << SEL_W,
  localparam int CNT_W  = TILE_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W-1:0] wr_old,
  input  logic              clr,
  input  logic [TILE_W-1:0] list_idx,
  output logic [TILE_W-1:0] list_tile,
  output logic [CNT_W-1:0]  list_count,
  input  logic [TILE_W-1:0] mask_tile,
  output logic [MASK_W-1:0] mask_bits
);
  logic              changed;
  logic [TILE_W-1:0] w_tile;
  logic [SEL_W-1:0]  w_sel;
  logic              first_touch;
  logic              append;

  always_comb begin
    changed = wr_en && (wr_data != wr_old);
    w_tile  = wr_addr[ADDR_W-1:TILE_LOG2];
    w_sel   = wr_addr[TILE_LOG2-1:GROUP_LOG2];
    append  = changed && first_touch && !clr;
  end

  tdt_mask_store #(.TILE_W(TILE_W), .SEL_W(SEL_W)) u_masks (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr         (clr),
    .upd_en      (changed),
    .upd_tile    (w_tile),
    .upd_sel     (w_sel),
    .first_touch (first_touch),
    .rd_tile     (mask_tile),
    .rd_mask     (mask_bits)
  );

  tdt_tile_list #(.TILE_W(TILE_W)) u_list (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .push      (append),
    .push_tile (w_tile),
    .rd_idx    (list_idx),
    .rd_tile   (list_tile),
    .count     (list_count)
  );

  // R3
  growth_needs_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (list_count == $past(list_count) + CNT_W'(1)) |-> $past(wr_en && (wr_data != wr_old) && !clr));

  // R6
  no_relist_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!first_touch && !clr) |=> (list_count == $past(list_count)));
endmodule

// File: tb/tdt_tracker_tb.sv
`timescale 1ns/1ps
module tdt_tracker_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en, clr;
  logic [13:0] wr_addr;
  logic [7:0] wr_data, wr_old;
  logic [8:0] list_idx, mask_tile;
  logic [8:0] list_tile;
  logic [9:0] list_count;
  logic [7:0] mask_bits;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int exp_mask [512];
  int exp_list [512];
  int exp_cnt;

  always #2 clk = ~clk;

  tdt_tracker u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_old(wr_old), .clr(clr), .list_idx(list_idx),
    .list_tile(list_tile), .list_count(list_count), .mask_tile(mask_tile),
    .mask_bits(mask_bits)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < 512; i++) exp_mask[i] = 0;
    exp_cnt = 0;
  endtask

  task automatic wr(input int addr, input int nv, input int ov, input bit with_clr = 0);
    int t, b;
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 14'(addr); wr_data = 8'(nv); wr_old = 8'(ov); clr = with_clr;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; clr = 1'b0;
    if (with_clr) model_clear();
    else if (nv != ov) begin
      t = (addr >> 5) & 511;
      b = (addr >> 2) & 7;
      if (exp_mask[t] == 0) begin
        exp_list[exp_cnt] = t;
        exp_cnt++;
      end
      exp_mask[t] |= (1 << b);
    end
  endtask

  task automatic rd_list(input int idx, output int v);
    @(negedge clk);
    list_idx = 9'(idx);
    @(posedge clk);
    @(negedge clk);
    v = int'(list_tile);
  endtask

  task automatic rd_mask(input int t, output int v);
    @(negedge clk);
    mask_tile = 9'(t);
    @(posedge clk);
    @(negedge clk);
    v = int'(mask_bits);
  endtask

  task automatic t_reset();
    int v;
    chk("R1 count", int'(list_count), 0);
    rd_mask(0, v);   chk("R1 mask0", v, 0);
    rd_mask(511, v); chk("R1 mask511", v, 0);
    rd_list(0, v);   chk("R1 entry0", v, 0);
  endtask

  task automatic t_addr_map();
    int v;
    wr(14'h3FFC, 8'h11, 8'h00);
    rd_mask(511, v); chk("R2 top tile bit7", v, exp_mask[511]);
    chk("R2 top tile bit7 value", v, 8'h80);
    wr(14'h0024, 8'h01, 8'h02);
    rd_mask(1, v); chk("R2 tile1 bit1", v, 8'h02);
    rd_mask(0, v); chk("R2 neighbour untouched", v, 0);
  endtask

  task automatic t_same();
    int v, c0;
    c0 = exp_cnt;
    wr(5 * 32 + 8, 8'h5A, 8'h5A);
    chk("R3 count unchanged", int'(list_count), c0);
    rd_mask(5, v); chk("R3 mask unchanged", v, 0);
  endtask

  task automatic t_accum();
    int v, c0;
    c0 = exp_cnt;
    wr(32 + 0,  8'h01, 8'h00);
    wr(32 + 31, 8'h01, 8'h00);
    wr(32 + 5,  8'h07, 8'h00);
    rd_mask(1, v); chk("R4 accumulated mask", v, 8'h83);
    chk("R6 no duplicate append", int'(list_count), c0);
  endtask

  task automatic t_order();
    int v;
    wr(300 * 32 + 12, 8'h01, 8'h00);
    wr(7 * 32 + 16,   8'h01, 8'h00);
    wr(100 * 32,      8'h01, 8'h00);
    chk("R5 count after appends", int'(list_count), 5);
    for (int i = 0; i < exp_cnt; i++) begin
      rd_list(i, v); chk("R7 entry order", v, exp_list[i]);
    end
    rd_list(exp_cnt, v); chk("R9 entry beyond count", v, 0);
  endtask

  task automatic t_latency();
    int v;
    @(negedge clk);
    mask_tile = 9'd300;
    @(posedge clk);
    #0.5 v = int'(mask_bits);
    chk("R9 mask after one edge", v, 8'h08);
  endtask

  task automatic t_clear();
    int v;
    wr(200 * 32, 8'h01, 8'h00, 1'b1);
    chk("R8 count cleared", int'(list_count), 0);
    rd_mask(200, v); chk("R8 dropped write", v, 0);
    rd_mask(511, v); chk("R8 mask cleared", v, 0);
    rd_list(0, v);   chk("R8 list empty", v, 0);
  endtask

  task automatic t_refill();
    int v;
    wr(511 * 32 + 1, 8'h09, 8'h00);
    rd_mask(511, v); chk("R10 fresh mask", v, 8'h01);
    rd_list(0, v);   chk("R10 restart at entry 0", v, 511);
    chk("R10 count", int'(list_count), 1);
  endtask

  task automatic t_full();
    int v;
    wr(0, 8'h00, 8'h00, 1'b1);
    for (int t = 511; t >= 0; t--) wr(t * 32 + 4, 8'hFF, 8'h00);
    chk("R11 full count", int'(list_count), 512);
    rd_list(0, v);   chk("R11 first entry", v, 511);
    rd_list(255, v); chk("R11 middle entry", v, 256);
    rd_list(511, v); chk("R11 last entry", v, 0);
    wr(0, 8'h01, 8'h00);
    chk("R11 no growth past full", int'(list_count), 512);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; clr = 1'b0;
    wr_addr = '0; wr_data = '0; wr_old = '0; list_idx = '0; mask_tile = '0;
    model_clear();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_addr_map();
    t_same();
    t_accum();
    t_order();
    t_latency();
    t_clear();
    t_refill();
    t_full();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule